// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns a mouse report into a five-byte packet and places the bytes in a small byte queue. A host drains the queue through a simple read port. A report is a single-cycle strobe that carries signed X and Y motion deltas and the states of three buttons. The block latches the report, forms the packet, and writes one byte per clock into the queue. While it is writing it holds `busy`, and it ignores any report that arrives during that time.

The packet opens with a header byte. The header has a fixed pattern, and each button has its own bit, which reads 0 when the button is pressed. The header is followed by the X delta, then the negated Y delta, each limited to ±127 in two's complement, and then two zero bytes. When the queue is full, a byte that cannot be stored is lost. A read of the empty queue returns zero. A receive-available flag stays high for as long as the queue holds a byte.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: After reset `rx_avail` and `busy` are 0, and `rd_data` reads 0x00.
- R2: The first packet byte is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared for the middle button, and bit 0 cleared for the right button (each button input is 1 when pressed).
- R3: The second byte is the 16-bit signed X delta limited to the range -127..+127, in 8-bit two's complement (values above 127 give 0x7F, values below -127 give 0x81).
- R4: The third byte is the negated 16-bit signed Y delta limited to -127..+127. -32768 gives 0x7F.
- R5: The fourth and fifth bytes are 0x00. Bytes leave the queue in the order header, X, Y, zero, zero.
- R6: A report strobed while `busy` is 0 sets `busy` on the next clock. One byte is queued on each of the following five clocks, and `busy` is 0 after the fifth.
- R7: A report strobed while `busy` is 1 produces no bytes.
- R8: The queue holds DEPTH bytes (default 16). A byte queued while the queue is full and no read takes place in that cycle is dropped. If a read takes place in the same cycle, the byte is kept.
- R9: A read strobe on an empty queue returns 0x00 and changes nothing.
- R10: `rx_avail` is 1 exactly while the queue holds at least one byte. Bytes come out first-in, first-out.
- R11: `rd_data` shows the oldest byte in the same cycle as `rd_strobe`. The byte is removed at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Report strobe, one cycle |
| rpt_dx | input | 16 | Signed X motion delta |
| rpt_dy | input | 16 | Signed Y motion delta |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| rd_strobe | input | 1 | Remove the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte, 0x00 when empty |
| rx_avail | output | 1 | Queue not empty |
| busy | output | 1 | Packet bytes still being queued |

## Verification
Two functions can land in the same clock: the packet writer pushing a byte and the host popping one. Both matter most when the queue is full. The bench first fills the queue to DEPTH with four reports, so the tail of the last packet is dropped. It then strobes a fifth report and holds `rd_strobe` through all five of its push cycles. It judges the outcome by reading back every remaining byte. The first packet should be gone, the fifth should be stored whole behind the kept header, and the queue should then be empty.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
   localparam int PKT_LEN = 5;
   localparam logic [7:0] HDR_BASE = 8'h87;
   localparam int BTN_L_BIT = 2;
   localparam int BTN_M_BIT = 1;
   localparam int BTN_R_BIT = 0;
   typedef logic [7:0] byte_t;
   typedef byte_t [PKT_LEN-1:0] pkt_t;
endpackage

// File: rtl/mpe_clamp.sv
module mpe_clamp #(
   parameter int DELTA_W = 16,
   parameter int LIMIT   = 127,
   parameter bit NEGATE  = 1'b0
) (
   input  logic [DELTA_W-1:0] din,
   output logic [7:0]         dout
);
   localparam int EW = DELTA_W + 1;
   localparam logic signed [EW-1:0] HI = EW'(LIMIT);
   localparam logic signed [EW-1:0] LO = -EW'(LIMIT);

   if (LIMIT < 1 || LIMIT > 127) begin : g_bad_limit
      $error("mpe_clamp: LIMIT must lie in 1..127");
   end

   logic signed [EW-1:0] ext;

   if (NEGATE) begin : g_neg
      always_comb ext = -$signed({din[DELTA_W-1], din});
   end else begin : g_pos
      always_comb ext = $signed({din[DELTA_W-1], din});
   end

   always_comb begin
      if (ext > HI)      dout = HI[7:0];
      else if (ext < LO) dout = LO[7:0];
      else               dout = ext[7:0];
   end
endmodule

// File: rtl/mpe_packet_former.sv
module mpe_packet_former
   import mpe_pkg::*;
#(
   parameter int DELTA_W = 16,
   parameter int LIMIT   = 127
) (
   input  logic [DELTA_W-1:0] dx,
   input  logic [DELTA_W-1:0] dy,
   input  logic               b_left,
   input  logic               b_mid,
   input  logic               b_right,
   output pkt_t               pkt
);
   byte_t hdr, xb, yb;

   always_comb begin
      hdr = HDR_BASE;
      hdr[BTN_L_BIT] = HDR_BASE[BTN_L_BIT] ^ b_left;
      hdr[BTN_M_BIT] = HDR_BASE[BTN_M_BIT] ^ b_mid;
      hdr[BTN_R_BIT] = HDR_BASE[BTN_R_BIT] ^ b_right;
   end

   mpe_clamp #(.DELTA_W(DELTA_W), .LIMIT(LIMIT), .NEGATE(1'b0)) u_clamp_x (
      .din (dx),
      .dout(xb)
   );

   mpe_clamp #(.DELTA_W(DELTA_W), .LIMIT(LIMIT), .NEGATE(1'b1)) u_clamp_y (
      .din (dy),
      .dout(yb)
   );

   assign pkt[0] = hdr;
   assign pkt[1] = xb;
   assign pkt[2] = yb;

   for (genvar i = 3; i < PKT_LEN; i++) begin : g_trail
      assign pkt[i] = 8'h00;
   end
endmodule

// File: rtl/mpe_sequencer.sv
module mpe_sequencer
   import mpe_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  pkt_t  pkt_in,
   output logic  push,
   output byte_t push_data,
   output logic  busy
);
   localparam int IW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
   localparam logic [IW-1:0] LAST = IW'(PKT_LEN - 1);

   pkt_t          held;
   logic [IW-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         held <= '0;
      end else if (!busy) begin
         if (start) begin
            held <= pkt_in;
            idx  <= '0;
            busy <= 1'b1;
         end
      end else begin
         if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign push      = busy;
   assign push_data = held[idx];
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 push_data,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         not_empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mpe_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_pop, do_push;

   assign not_empty = (count != '0);
   assign do_pop    = pop && not_empty;
   assign do_push   = push && ((count != FULL_CNT) || do_pop);
   assign head      = not_empty ? mem[rptr] : '0;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
         if (do_pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/mouse_pkt_encoder.sv
module mouse_pkt_encoder
   import mpe_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int DELTA_W = 16,
   parameter int LIMIT   = 127
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rpt_valid,
   input  logic [DELTA_W-1:0] rpt_dx,
   input  logic [DELTA_W-1:0] rpt_dy,
   input  logic               btn_left,
   input  logic               btn_mid,
   input  logic               btn_right,
   input  logic               rd_strobe,
   output logic [7:0]         rd_data,
   output logic               rx_avail,
   output logic               busy
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DELTA_W < 8) begin : g_bad_width
      $error("mouse_pkt_encoder: DELTA_W must be at least 8");
   end

   pkt_t          formed;
   logic          q_push;
   byte_t         q_wdata;
   logic [CW-1:0] q_count;

   mpe_packet_former #(.DELTA_W(DELTA_W), .LIMIT(LIMIT)) u_former (
      .dx     (rpt_dx),
      .dy     (rpt_dy),
      .b_left (btn_left),
      .b_mid  (btn_mid),
      .b_right(btn_right),
      .pkt    (formed)
   );

   mpe_sequencer u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (rpt_valid),
      .pkt_in   (formed),
      .push     (q_push),
      .push_data(q_wdata),
      .busy     (busy)
   );

   mpe_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (q_push),
      .push_data(q_wdata),
      .pop      (rd_strobe),
      .head     (rd_data),
      .count    (q_count),
      .not_empty(rx_avail)
   );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker #(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rpt_valid,
   input logic                       busy,
   input logic                       rd_strobe,
   input logic [7:0]                 rd_data,
   input logic                       rx_avail,
   input logic                       q_push,
   input logic [$clog2(DEPTH+1)-1:0] q_count
);
   assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid && !busy |=> busy);

   assert_busy_min_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);

   assert_no_push_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !q_push);

   assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_avail |-> rd_data == 8'h00);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= DEPTH);

   assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == DEPTH) && q_push && !rd_strobe |=> q_count == DEPTH);

   assert_pop_decrements_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && rx_avail && !q_push |=> q_count == $past(q_count) - 1'b1);

   assert_empty_read_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !rx_avail && !q_push |=> !rx_avail);
endmodule

bind mouse_pkt_encoder mpe_checker #(.DEPTH(DEPTH)) u_mpe_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rpt_valid(rpt_valid),
   .busy     (busy),
   .rd_strobe(rd_strobe),
   .rd_data  (rd_data),
   .rx_avail (rx_avail),
   .q_push   (q_push),
   .q_count  (q_count)
);

// File: tb/mouse_pkt_encoder_test.sv
module mouse_pkt_encoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rpt_valid = 1'b0;
   logic [15:0] rpt_dx = '0, rpt_dy = '0;
   logic        btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [7:0]  rd_data;
   logic        rx_avail, busy;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mouse_pkt_encoder uut (
      .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid),
      .rpt_dx(rpt_dx), .rpt_dy(rpt_dy),
      .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
      .rd_strobe(rd_strobe), .rd_data(rd_data),
      .rx_avail(rx_avail), .busy(busy)
   );

   // {dx, dy, buttons {L,M,R} in low 3 bits, header, x byte, y byte}
   localparam logic [63:0] VECS [9] = '{
      {16'h0000, 16'h0000, 8'h00, 8'h87, 8'h00, 8'h00},
      {16'h0005, 16'h0003, 8'h04, 8'h83, 8'h05, 8'hFD},
      {16'hFFFB, 16'hFFFD, 8'h02, 8'h85, 8'hFB, 8'h03},
      {16'h00C8, 16'hFF38, 8'h01, 8'h86, 8'h7F, 8'h7F},
      {16'hFF38, 16'h00C8, 8'h07, 8'h80, 8'h81, 8'h81},
      {16'h007F, 16'hFF81, 8'h05, 8'h82, 8'h7F, 8'h7F},
      {16'hFF80, 16'h0080, 8'h03, 8'h84, 8'h81, 8'h81},
      {16'h8000, 16'h8000, 8'h00, 8'h87, 8'h81, 8'h7F},
      {16'h7FFF, 16'h7FFF, 8'h06, 8'h81, 8'h7F, 8'h81}
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   // returns at the falling edge right after the accepting rising edge
   task automatic send_report(input logic [15:0] dx, input logic [15:0] dy, input logic [2:0] b);
      @(negedge clk);
      rpt_dx = dx; rpt_dy = dy;
      btn_left = b[2]; btn_mid = b[1]; btn_right = b[0];
      rpt_valid = 1'b1;
      @(negedge clk);
      rpt_valid = 1'b0;
   endtask

   task automatic read_byte(output logic [7:0] v);
      @(negedge clk);
      rd_strobe = 1'b1;
      #1 v = rd_data;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic read_expect(input string req, input logic [7:0] exp);
      logic [7:0] v;
      read_byte(v);
      check8(req, v, exp);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      // R1 reset state
      repeat (3) @(negedge clk);
      check1("R1 rx_avail", rx_avail, 1'b0);
      check1("R1 busy", busy, 1'b0);
      check8("R1 rd_data", rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check1("R1 rx_avail after release", rx_avail, 1'b0);

      // vector walk: R2 R3 R4 R5 R10
      for (int i = 0; i < 9; i++) begin
         send_report(VECS[i][63:48], VECS[i][47:32], VECS[i][26:24]);
         repeat (5) @(negedge clk);
         check1("R10 avail after packet", rx_avail, 1'b1);
         read_expect("R2 header", VECS[i][23:16]);
         read_expect("R3 x byte", VECS[i][15:8]);
         read_expect("R4 y byte", VECS[i][7:0]);
         read_expect("R5 zero 4", 8'h00);
         read_expect("R5 zero 5", 8'h00);
         @(negedge clk);
         check1("R10 empty after drain", rx_avail, 1'b0);
      end

      // R6 busy timing and R7 report ignored while busy
      send_report(16'h0009, 16'h0000, 3'b000);
      check1("R6 busy after accept", busy, 1'b1);
      rpt_dx = 16'h0055; rpt_valid = 1'b1;
      @(negedge clk);
      rpt_valid = 1'b0;
      check1("R6 busy mid packet", busy, 1'b1);
      repeat (3) @(negedge clk);
      check1("R6 busy before fifth push", busy, 1'b1);
      @(negedge clk);
      check1("R6 busy clear after fifth push", busy, 1'b0);
      read_expect("R7 header", 8'h87);
      read_expect("R7 x of first report", 8'h09);
      read_expect("R7 y", 8'h00);
      read_expect("R7 zero", 8'h00);
      read_expect("R7 zero", 8'h00);
      @(negedge clk);
      check1("R7 no second packet", rx_avail, 1'b0);

      // R8 overflow: four packets into 16 entries
      for (int k = 1; k <= 4; k++) begin
         send_report(16'(k), 16'h0000, 3'b000);
         repeat (5) @(negedge clk);
      end
      check1("R8 full avail", rx_avail, 1'b1);

      // R8 / R11 push and pop in the same cycles while full
      send_report(16'h0005, 16'h0000, 3'b000);
      rd_strobe = 1'b1;
      for (int j = 0; j < 5; j++) begin
         #1 check8("R11 head during simultaneous pop", rd_data, (j == 0) ? 8'h87 : ((j == 1) ? 8'h01 : 8'h00));
         @(negedge clk);
      end
      rd_strobe = 1'b0;
      check1("R6 busy clear", busy, 1'b0);
      for (int k = 2; k <= 3; k++) begin
         read_expect("R8 kept header", 8'h87);
         read_expect("R8 kept x", 8'(k));
         read_expect("R8 kept y", 8'h00);
         read_expect("R8 kept zero", 8'h00);
         read_expect("R8 kept zero", 8'h00);
      end
      read_expect("R8 partial header kept", 8'h87);
      read_expect("R8 same-cycle header", 8'h87);
      read_expect("R8 same-cycle x", 8'h05);
      read_expect("R8 same-cycle y", 8'h00);
      read_expect("R8 same-cycle zero", 8'h00);
      read_expect("R8 same-cycle zero", 8'h00);
      @(negedge clk);
      check1("R8 drained", rx_avail, 1'b0);

      // R9 empty reads
      read_byte(v);
      check8("R9 empty read", v, 8'h00);
      read_byte(v);
      check8("R9 empty read again", v, 8'h00);
      check1("R9 still empty", rx_avail, 1'b0);
      send_report(16'hFFFF, 16'h0001, 3'b100);
      repeat (5) @(negedge clk);
      read_expect("R9 queue intact header", 8'h83);
      read_expect("R9 queue intact x", 8'hFF);
      read_expect("R9 queue intact y", 8'hFF);
      read_expect("R5 zero", 8'h00);
      read_expect("R5 zero", 8'h00);

      finish_run();
   end
endmodule